// File: doc/BRIEF.md
# Coprocessor Bus Front End

This block sits between a processor's two-phase data bus and an arithmetic coprocessor. Every cycle it decodes a 6-bit command and moves 32-bit words between the bus and the coprocessor's architectural state. That state is a Control word and four operand words: Left, Leftx, Right and Rightx. It also exposes two derived words, Result and Resultx, which the compute engine produces from that state. The bus supplies two data words per cycle. The phase-A word is an input only. The phase-B word is an input for writes and the block's output for reads.

Any write to state restarts the engine. A command that reads a result word, or moves the results back into an operand pair, must wait for the engine. The block raises `reject_o` for as long as the engine is busy, and the issuer repeats the command until `reject_o` is low. When the read completes, the engine's exception bits are merged into the sticky flag byte. If a flag is set and its mask bit is clear, the block reports a fault code and moves no data. A stub engine with a programmable latency stands in for the arithmetic. It computes Result = Left + Right and Resultx = Leftx ^ Rightx, and it raises exception bits equal to Leftx[5:0].

Top module: `cop_frontend`

## Requirements
- R1: After reset all five state words are zero, the engine is idle, `reject_o` is 0 and `fault_o` is 0.
- R2: A command is {valid, fn, code[3:0]} on `cmd_i[5:0]`. When valid is 1, code 0 loads Left from B. Code 1 loads Left from B and Leftx from A. Code 2 loads Right from B. Code 3 loads Right from B and Rightx from A. Code 4 loads Control from B. Code 5 loads Left from B and Right from A.
- R3: Codes 8, 9, 10, 11 and 12 drive Left, Leftx, Right, Rightx and Control onto `bus_b_o` with `bus_b_oe_o` high. Code 13 does nothing and leaves `bus_b_oe_o` low.
- R4: When fn is 1, the low byte of A is written to Control[7:0], which is the function byte. If the same command loads Control from B, the B value wins. When fn is combined with code 1, 3 or 5, the function write is ignored.
- R5: A command with valid at 0 changes no state and drives nothing.
- R6: Codes 6, 7, 14 and 15 assert `reject_o` while the engine is busy. The engine is busy for exactly `eng_lat_i` cycles after the cycle that restarted it. No other command ever rejects or faults.
- R7: A completed read with code 14 or 15 drives Result or Resultx and ORs the engine's exception bits into the flag byte, Control[21:16].
- R8: Flag bit k is held at Control[16+k] and its mask bit at Control[24+k]. Bit 0 is invalid, bit 1 is divide by zero, bit 2 is overflow, bit 3 is underflow, bit 4 is inexact and bit 5 is fixed divide overflow. On a completed result read, if any merged flag is set with its mask bit clear, `fault_o` shows k+1 for the lowest such k. In that case no data is driven or moved.
- R9: A completed code 6 without a fault copies Result and Resultx into Left and Leftx. A completed code 7 without a fault copies them into Right and Rightx.
- R10: Every state write restarts the engine, including codes 6 and 7 and a lone function write. A command issued while `reject_o` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 6 | Command {valid, fn, code[3:0]} |
| bus_a_i | input | 32 | Phase-A data word |
| bus_b_i | input | 32 | Phase-B data word (write direction) |
| eng_lat_i | input | 8 | Stub engine latency in cycles, captured on restart |
| bus_b_o | output | 32 | Phase-B data word (read direction) |
| bus_b_oe_o | output | 1 | Phase-B drive enable |
| reject_o | output | 1 | Command must be repeated; engine busy |
| fault_o | output | 4 | Fault code, 0 when no fault |

## Verification
The bench counts the reject cycles after a restart and expects the exact latency. A design that miscounts the engine by one cycle, or that lets a repeated rejected command restart the engine, would either hand out a stale result or never finish. The bench gives the function byte three conflicting sources: a lone function write, a function write alongside a Control load, and a function write alongside a two-word load. A wrong priority shows up in the Control read-back. The bench also checks faults with several flags set, where the lowest unmasked bit decides the code, and with a code 7 that faults. A design that moved the data anyway would corrupt Right.

// File: rtl/cop_pkg.sv
package cop_pkg;
    parameter int WORD_W = 32;
    parameter int FLAG_N = 6;
    parameter int FCODE_W = 4;

    localparam int FN_LSB   = 0;
    localparam int FLAG_LSB = 16;
    localparam int MASK_LSB = 24;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t ctrl;
        word_t left;
        word_t leftx;
        word_t right;
        word_t rightx;
    } state_t;

    typedef struct packed {
        logic       valid;
        logic       fn_wr;
        logic [3:0] code;
        logic       res_rd;
        logic       rd_plain;
        logic       fn_legal;
    } dec_t;
endpackage

// File: rtl/cop_decode.sv
module cop_decode
    import cop_pkg::*;
(
    input  logic [5:0] cmd_i,
    output dec_t       dec_o
);
    logic [3:0] code;

    always_comb begin
        code            = cmd_i[3:0];
        dec_o.valid     = cmd_i[5];
        dec_o.fn_wr     = cmd_i[5] & cmd_i[4];
        dec_o.code      = code;
        dec_o.res_rd    = cmd_i[5] & (code[2:1] == 2'b11);
        dec_o.rd_plain  = cmd_i[5] & code[3] & (code[2:0] <= 3'd4);
        dec_o.fn_legal  = !(code == 4'd1 || code == 4'd3 || code == 4'd5);
    end
endmodule

// File: rtl/cop_stub_engine.sv
module cop_stub_engine
    import cop_pkg::*;
#(
    parameter int LAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic [LAT_W-1:0]  lat_i,
    input  word_t             left_i,
    input  word_t             leftx_i,
    input  word_t             right_i,
    input  word_t             rightx_i,
    output word_t             res_o,
    output word_t             resx_o,
    output logic [FLAG_N-1:0] raise_o,
    output logic              done_o,
    output logic [LAT_W-1:0]  cnt_o
);
    logic [LAT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i)
            cnt_d = lat_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign res_o   = left_i + right_i;
    assign resx_o  = leftx_i ^ rightx_i;
    assign raise_o = leftx_i[FLAG_N-1:0];
    assign done_o  = (cnt_q == '0);
    assign cnt_o   = cnt_q;
endmodule

// File: rtl/cop_fault_enc.sv
module cop_fault_enc
    import cop_pkg::*;
(
    input  logic [FLAG_N-1:0]  hit_i,
    output logic [FLAG_N-1:0]  first_o,
    output logic [FCODE_W-1:0] code_o
);
    genvar gi;
    generate
        for (gi = 0; gi < FLAG_N; gi++) begin : g_first
            if (gi == 0) begin : g_lsb
                assign first_o[gi] = hit_i[gi];
            end else begin : g_up
                assign first_o[gi] = hit_i[gi] & ~|hit_i[gi-1:0];
            end
        end
    endgenerate

    always_comb begin
        code_o = '0;
        for (int k = 0; k < FLAG_N; k++)
            if (first_o[k]) code_o = code_o | FCODE_W'(k + 1);
    end
endmodule

// File: rtl/cop_frontend.sv
module cop_frontend
    import cop_pkg::*;
#(
    parameter int LAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        cmd_i,
    input  logic [31:0]       bus_a_i,
    input  logic [31:0]       bus_b_i,
    input  logic [LAT_W-1:0]  eng_lat_i,
    output logic [31:0]       bus_b_o,
    output logic              bus_b_oe_o,
    output logic              reject_o,
    output logic [3:0]        fault_o
);
    state_t state_d, state_q;
    dec_t   dec;
    logic   restart;
    word_t  res, resx;
    logic [FLAG_N-1:0]  raise, flags_new, unmasked, first;
    logic [FCODE_W-1:0] fcode;
    logic               done;
    logic [LAT_W-1:0]   eng_cnt;

    cop_decode u_dec (.cmd_i(cmd_i), .dec_o(dec));

    cop_stub_engine #(.LAT_W(LAT_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .restart_i(restart), .lat_i(eng_lat_i),
        .left_i(state_q.left), .leftx_i(state_q.leftx),
        .right_i(state_q.right), .rightx_i(state_q.rightx),
        .res_o(res), .resx_o(resx), .raise_o(raise),
        .done_o(done), .cnt_o(eng_cnt)
    );

    assign flags_new = state_q.ctrl[FLAG_LSB +: FLAG_N] | raise;
    assign unmasked  = flags_new & ~state_q.ctrl[MASK_LSB +: FLAG_N];

    cop_fault_enc u_enc (.hit_i(unmasked), .first_o(first), .code_o(fcode));

    always_comb begin
        logic go, faulted;
        state_d    = state_q;
        restart    = 1'b0;
        bus_b_o    = '0;
        bus_b_oe_o = 1'b0;
        reject_o   = dec.res_rd & ~done;
        go         = dec.valid & ~reject_o;
        faulted    = go & dec.res_rd & (fcode != '0);
        fault_o    = faulted ? fcode : '0;

        if (go) begin
            if (dec.res_rd)
                state_d.ctrl[FLAG_LSB +: FLAG_N] = flags_new;
            if (dec.fn_wr && dec.fn_legal) begin
                state_d.ctrl[FN_LSB +: 8] = bus_a_i[7:0];
                restart = 1'b1;
            end
            case (dec.code)
                4'd0: begin state_d.left = bus_b_i; restart = 1'b1; end
                4'd1: begin
                    state_d.left  = bus_b_i;
                    state_d.leftx = bus_a_i;
                    restart       = 1'b1;
                end
                4'd2: begin state_d.right = bus_b_i; restart = 1'b1; end
                4'd3: begin
                    state_d.right  = bus_b_i;
                    state_d.rightx = bus_a_i;
                    restart        = 1'b1;
                end
                4'd4: begin state_d.ctrl = bus_b_i; restart = 1'b1; end
                4'd5: begin
                    state_d.left  = bus_b_i;
                    state_d.right = bus_a_i;
                    restart       = 1'b1;
                end
                4'd6: if (!faulted) begin
                    state_d.left  = res;
                    state_d.leftx = resx;
                    restart       = 1'b1;
                end
                4'd7: if (!faulted) begin
                    state_d.right  = res;
                    state_d.rightx = resx;
                    restart        = 1'b1;
                end
                4'd8:  begin bus_b_o = state_q.left;   bus_b_oe_o = 1'b1; end
                4'd9:  begin bus_b_o = state_q.leftx;  bus_b_oe_o = 1'b1; end
                4'd10: begin bus_b_o = state_q.right;  bus_b_oe_o = 1'b1; end
                4'd11: begin bus_b_o = state_q.rightx; bus_b_oe_o = 1'b1; end
                4'd12: begin bus_b_o = state_q.ctrl;   bus_b_oe_o = 1'b1; end
                4'd14: if (!faulted) begin bus_b_o = res;  bus_b_oe_o = 1'b1; end
                4'd15: if (!faulted) begin bus_b_o = resx; bus_b_oe_o = 1'b1; end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/cop_frontend_chk.sv
module cop_frontend_chk
    import cop_pkg::*;
#(
    parameter int LAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [5:0]        cmd_i,
    input logic [LAT_W-1:0]  eng_lat_i,
    input logic              bus_b_oe_o,
    input logic              reject_o,
    input logic [3:0]        fault_o,
    input logic              restart,
    input logic [LAT_W-1:0]  eng_cnt,
    input state_t            state_q,
    input logic [FLAG_N-1:0] first
);
    logic res_code;
    assign res_code = cmd_i[5] & (cmd_i[3:0] == 4'd6 || cmd_i[3:0] == 4'd7 ||
                                  cmd_i[3:0] == 4'd14 || cmd_i[3:0] == 4'd15);

    p_reset_clear_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (state_q == '0 && eng_cnt == '0));

    p_oe_reads_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_b_oe_o |-> (cmd_i[5] && cmd_i[3] && cmd_i[3:0] != 4'd13));

    p_quiet_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !res_code |-> (!reject_o && fault_o == 4'd0));

    p_fault_no_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o != 4'd0) |-> !bus_b_oe_o);

    p_single_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(first));

    p_restart_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (eng_cnt == $past(eng_lat_i)));

    p_reject_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reject_o |=> (state_q == $past(state_q)));
endmodule

bind cop_frontend cop_frontend_chk #(.LAT_W(LAT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .eng_lat_i(eng_lat_i),
    .bus_b_oe_o(bus_b_oe_o), .reject_o(reject_o), .fault_o(fault_o),
    .restart(restart), .eng_cnt(eng_cnt), .state_q(state_q), .first(first)
);

// File: tb/sim_cop_frontend.sv
`timescale 1ns/1ps
module sim_cop_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cmd_i = '0;
    logic [31:0] bus_a_i = '0, bus_b_i = '0;
    logic [7:0]  eng_lat_i = '0;
    logic [31:0] bus_b_o;
    logic        bus_b_oe_o, reject_o;
    logic [3:0]  fault_o;
    int errors = 0, checks = 0;

    always #5 clk = ~clk;

    cop_frontend u0 (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bus_a_i(bus_a_i),
        .bus_b_i(bus_b_i), .eng_lat_i(eng_lat_i), .bus_b_o(bus_b_o),
        .bus_b_oe_o(bus_b_oe_o), .reject_o(reject_o), .fault_o(fault_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [5:0] c, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        cmd_i = c; bus_a_i = a; bus_b_i = b;
        #1;
    endtask

    task automatic wr(input logic [3:0] code, input logic [31:0] a, input logic [31:0] b);
        issue({2'b10, code}, a, b);
    endtask

    task automatic rd(input logic [3:0] code, output logic [31:0] d);
        issue({2'b10, code}, '0, '0);
        d = bus_b_o;
    endtask

    task automatic res_op(input logic [3:0] code, output int nrej,
                          output logic [31:0] d, output logic [3:0] f, output logic oe);
        issue({2'b10, code}, '0, '0);
        nrej = 0;
        while (reject_o && nrej < 1000) begin
            nrej++;
            @(negedge clk); #1;
        end
        d = bus_b_o; f = fault_o; oe = bus_b_oe_o;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 reject after reset", reject_o, 0);
        chk("R1 fault after reset", fault_o, 0);
        for (int c = 8; c <= 12; c++) begin
            rd(c[3:0], d);
            chk("R1 state word zero", d, 0);
            chk("R3 read enable", bus_b_oe_o, 1);
        end
    endtask

    task automatic t_writes();
        logic [31:0] d;
        eng_lat_i = 0;
        wr(4'd0, 32'h0, 32'h1111_0000);
        rd(4'd8, d);  chk("R2 code0 left", d, 32'h1111_0000);
        wr(4'd1, 32'hA0A0_0001, 32'h2222_0000);
        rd(4'd8, d);  chk("R2 code1 left", d, 32'h2222_0000);
        rd(4'd9, d);  chk("R2 code1 leftx", d, 32'hA0A0_0001);
        wr(4'd2, 32'h0, 32'h3333_0000);
        rd(4'd10, d); chk("R2 code2 right", d, 32'h3333_0000);
        wr(4'd3, 32'hB0B0_0002, 32'h4444_0000);
        rd(4'd11, d); chk("R2 code3 rightx", d, 32'hB0B0_0002);
        wr(4'd4, 32'h0, 32'h3F00_1234);
        rd(4'd12, d); chk("R2 code4 control", d, 32'h3F00_1234);
        wr(4'd5, 32'h5555_0000, 32'h6666_0000);
        rd(4'd8, d);  chk("R2 code5 left", d, 32'h6666_0000);
        rd(4'd10, d); chk("R2 code5 right", d, 32'h5555_0000);
    endtask

    task automatic t_nop();
        logic [31:0] d;
        wr(4'd13, 32'h0, 32'h0);
        chk("R3 code13 no drive", bus_b_oe_o, 0);
        issue(6'b000000, 32'h0, 32'hDEAD_BEEF);
        chk("R5 invalid no drive", bus_b_oe_o, 0);
        issue(6'b011010, 32'h0, 32'h0);
        chk("R5 invalid read no drive", bus_b_oe_o, 0);
        rd(4'd8, d);  chk("R5 left kept", d, 32'h6666_0000);
    endtask

    task automatic t_func();
        logic [31:0] d;
        wr(4'd4, 32'h0, 32'h1122_3344);
        issue(6'b111101, 32'h0000_00A5, 32'h0);
        rd(4'd12, d); chk("R4 function byte", d, 32'h1122_33A5);
        issue(6'b110100, 32'h0000_00CC, 32'h5566_7788);
        rd(4'd12, d); chk("R4 phase B wins", d, 32'h5566_7788);
        issue(6'b110001, 32'h0000_00EE, 32'h0000_0009);
        rd(4'd12, d); chk("R4 illegal fn ignored", d, 32'h5566_7788);
        rd(4'd9, d);  chk("R4 code1 data kept", d, 32'h0000_00EE);
    endtask

    task automatic t_latency();
        int n; logic [31:0] d; logic [3:0] f; logic oe;
        wr(4'd4, 32'h0, 32'h3F00_0000);
        eng_lat_i = 3;
        wr(4'd0, 32'h0, 32'd5);
        wr(4'd2, 32'h0, 32'd7);
        res_op(4'd14, n, d, f, oe);
        chk("R6 reject cycles", n, 3);
        chk("R7 result value", d, 32'd12);
        chk("R7 result drive", oe, 1);
        eng_lat_i = 2;
        issue(6'b111101, 32'h0000_0001, 32'h0);
        res_op(4'd15, n, d, f, oe);
        chk("R10 fn write restarts", n, 2);
        chk("R7 resultx", d, 32'h0000_00EE ^ 32'hB0B0_0002);
    endtask

    task automatic t_fault();
        int n; logic [31:0] d; logic [3:0] f; logic oe;
        eng_lat_i = 0;
        wr(4'd4, 32'h0, 32'h0);
        wr(4'd1, 32'h0000_0004, 32'h0);
        res_op(4'd15, n, d, f, oe);
        chk("R8 fault code overflow", f, 3);
        chk("R8 no drive on fault", oe, 0);
        rd(4'd12, d); chk("R7 flag merged", d, 32'h0004_0000);
        wr(4'd4, 32'h0, 32'h3F00_0000);
        res_op(4'd15, n, d, f, oe);
        chk("R8 masked no fault", f, 0);
        chk("R7 masked data", d, 32'h0000_0004 ^ 32'hB0B0_0002);
        rd(4'd12, d); chk("R7 flags sticky", d, 32'h3F04_0000);
        wr(4'd1, 32'h0000_0030, 32'h0);
        wr(4'd4, 32'h0, 32'h1000_0000);
        res_op(4'd14, n, d, f, oe);
        chk("R8 lowest unmasked", f, 6);
        wr(4'd1, 32'h0, 32'h0);
        wr(4'd4, 32'h0, 32'h000A_0000);
        res_op(4'd14, n, d, f, oe);
        chk("R8 preset flags priority", f, 2);
        wr(4'd13, 32'h0, 32'h0);
        chk("R6 non-result no fault", fault_o, 0);
    endtask

    task automatic t_move();
        int n; logic [31:0] d; logic [3:0] f; logic oe;
        eng_lat_i = 0;
        wr(4'd4, 32'h0, 32'h3F00_0000);
        wr(4'd1, 32'h0000_0100, 32'd3);
        wr(4'd3, 32'h0000_0011, 32'd4);
        res_op(4'd6, n, d, f, oe);
        chk("R9 code6 no fault", f, 0);
        rd(4'd8, d); chk("R9 left from result", d, 32'd7);
        rd(4'd9, d); chk("R9 leftx from resultx", d, 32'h0000_0111);
        eng_lat_i = 2;
        wr(4'd2, 32'h0, 32'd1);
        res_op(4'd7, n, d, f, oe);
        chk("R6 move waits", n, 2);
        res_op(4'd14, n, d, f, oe);
        chk("R10 move restarts", n, 2);
        rd(4'd10, d); chk("R9 right from result", d, 32'd8);
        rd(4'd11, d); chk("R9 rightx from resultx", d, 32'h0000_0100);
        eng_lat_i = 0;
        wr(4'd4, 32'h0, 32'h0);
        wr(4'd1, 32'h0000_0001, 32'd1);
        res_op(4'd7, n, d, f, oe);
        chk("R8 code7 fault", f, 1);
        rd(4'd10, d); chk("R8 no move on fault", d, 32'd8);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_writes();
        t_nop();
        t_func();
        t_latency();
        t_fault();
        t_move();
        @(negedge clk);
        cmd_i = '0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule